// File: doc/BRIEF.md
# Parallel-Port FIFO Service Interrupt Controller

This block holds the extended control register of a parallel port that moves bytes through a FIFO. It decides when the host processor gets an interrupt and when DMA may run. Software reads and writes one 8-bit control register through a small register port. The FIFO reports how many bytes are free and how many bytes are valid. The DMA engine gives a one-clock terminal-count strobe. A direction input says which way data flows, and the active-low fault line comes from the peripheral.

A service bit in the register sets itself when the FIFO needs attention, and it raises one interrupt pulse when it does. Which condition sets it depends on the DMA-enable bit and the direction. While the service bit is set, DMA is held off and no further service interrupts occur. Software writes the bit back to 0 to re-arm it. A separate path turns a falling edge on the fault line into an interrupt, unless that path is masked. Clearing the mask while the fault is already active also gives an interrupt. When the mode field selects configuration mode, the block decodes select strobes for two configuration registers that sit at fixed offsets from the port base.

Top module: `ppsvc_top`

## Requirements
- R1: Bit 4 of the control register masks the fault interrupt. While bit 4 is 0, a high-to-low transition of `fault_n` gives exactly one `irq` pulse. That pulse comes within four clocks of the transition, because of a two-flop synchronizer and an edge register. While bit 4 is 1, a falling edge gives no pulse.
- R2: A control write that changes bit 4 from 1 to 0 while the synchronized `fault_n` is low gives one `irq` pulse. The same write while `fault_n` is high gives none.
- R3: `dma_en_o` is high exactly when bit 3 (DMA enable) is 1 and bit 2 (service) is 0. While bit 3 is 0, `dma_en_o` is 0.
- R4: When bit 3 is 1 and bit 2 is 0, a `dma_tc` strobe sets bit 2 and gives one `irq` pulse. In this case the FIFO counts do not set the bit.
- R5: When bit 3 is 0, `dir` is 0 and bit 2 is 0, bit 2 is set with one `irq` pulse once `fifo_free` is at least WR_THRESH (default 8). A value of 7 does nothing.
- R6: When bit 3 is 0, `dir` is 1 and bit 2 is 0, bit 2 is set with one `irq` pulse once `fifo_valid` is at least RD_THRESH (default 8). A value of 7 does nothing.
- R7: While bit 2 is 1, no service condition gives an interrupt, even one that stays true. Hardware never clears bit 2; only a software write of 0 does. A software write of 1 gives no interrupt. Once the bit is cleared, a condition that is still true fires again.
- R8: Bit 1 reads 1 exactly when `fifo_free` is 0, and bit 0 reads 1 exactly when `fifo_valid` is 0. Writes to bits 1 and 0 have no effect.
- R9: Bits 7:5 hold the mode field, which can be written and read back. The control register is written only when `bus_wr` is high and `bus_addr` is 0x402. With mode 3'b111 (configuration), `cfg_a_sel` is high for `bus_addr` 0x400 and `cfg_b_sel` is high for 0x401. In any other mode both selects are low.
- R10: After reset the register holds mode 0, bit 4 = 1, bit 3 = 0 and bit 2 = 1. With `fifo_free` = 16 and `fifo_valid` = 0 it reads 0x15, and `irq` and `dma_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Register offset from the port base |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Current control register value, including the live full and empty flags |
| fifo_free | input | 5 | Number of free bytes in the FIFO |
| fifo_valid | input | 5 | Number of valid bytes in the FIFO |
| dma_tc | input | 1 | DMA terminal-count strobe |
| dir | input | 1 | Transfer direction: 0 host to peripheral, 1 peripheral to host |
| fault_n | input | 1 | Asynchronous active-low fault line from the peripheral |
| irq | output | 1 | One-clock interrupt pulse for each event |
| dma_en_o | output | 1 | DMA request enable |
| cfg_a_sel | output | 1 | Select for the first configuration register |
| cfg_b_sel | output | 1 | Select for the second configuration register |

## Verification
The bench holds a service condition true for many cycles after it fires and expects exactly one pulse. A design that evaluated conditions while the bit was set would keep pulsing, and one that fired again after a write of 1 would give an extra pulse. It steps the free and valid counts across the threshold from 7 to 8 in both directions, which exposes a comparison that is off by one or uses the wrong count for the direction. It clears the fault mask both with the fault line already low and with it high, so a design that misses the re-fire, or that fires on every mask write, shows a wrong pulse count. It also checks that DMA mode ignores the FIFO counts, and that writes to other offsets and to the read-only flags leave the register unchanged.

// File: rtl/ppsvc_pkg.sv
// Package: shared types and fixed decode constants for the parallel-port
// service interrupt controller. Assumes an 8-bit control register layout.
package ppsvc_pkg;

    // Writable part of the control register (bits 7:2).
    typedef struct packed {
        logic [2:0] mode;     // bits 7:5
        logic       err_dis;  // bit 4, 1 masks the fault interrupt
        logic       dma_en;   // bit 3
        logic       svc;      // bit 2, self-setting service flag
    } ctrl_t;

    localparam logic [2:0] MODE_CFG   = 3'b111;
    localparam int unsigned CFG_A_OFS = 32'h400;
    localparam int unsigned CFG_B_OFS = 32'h401;
    localparam int unsigned CTRL_OFS  = 32'h402;

    localparam ctrl_t CTRL_RST = '{mode: 3'b000, err_dis: 1'b1, dma_en: 1'b0, svc: 1'b1};

endpackage

// File: rtl/ppsvc_fault_sync.sv
// Module: ppsvc_fault_sync
// Brings the asynchronous active-low fault line into the clock domain with a
// SYNC_STAGES flop chain, then flags a one-cycle falling edge.
// Assumes fault_n is glitch-free for at least two clocks per level.
module ppsvc_fault_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    output logic fault_lvl_n,
    output logic fault_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain; idles high (no fault) out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n};
    end

    // Previous synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign fault_lvl_n = sync_q[SYNC_STAGES-1];
    assign fault_fall  = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ppsvc_svc_eval.sv
// Module: ppsvc_svc_eval
// Picks the service trigger source from the DMA enable and direction, and
// raises svc_fire when that source is active while the service flag is clear.
// Assumes the counts never exceed the FIFO depth.
module ppsvc_svc_eval #(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned WR_THRESH = 8,
    parameter int unsigned RD_THRESH = 8
) (
    input  logic             svc,
    input  logic             dma_en,
    input  logic             dir,
    input  logic             dma_tc,
    input  logic [CNT_W-1:0] fifo_free,
    input  logic [CNT_W-1:0] fifo_valid,
    output logic             svc_fire
);
    localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WR_THRESH);
    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_THRESH);

    logic cond;

    // Trigger source selection: terminal count, free space or valid data.
    always_comb begin
        if (dma_en)   cond = dma_tc;
        else if (dir) cond = (fifo_valid >= RD_LIM);
        else          cond = (fifo_free >= WR_LIM);
    end

    assign svc_fire = ~svc & cond;

endmodule

// File: rtl/ppsvc_ctrl_reg.sv
// Module: ppsvc_ctrl_reg
// Holds the control register, applies software writes and the hardware set
// of the service flag, forms read data, the configuration selects and the
// fault-mask re-arm event. Assumes one register access per clock.
module ppsvc_ctrl_reg
    import ppsvc_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic [CNT_W-1:0]  fifo_free,
    input  logic [CNT_W-1:0]  fifo_valid,
    input  logic              svc_fire,
    input  logic              fault_lvl_n,
    output ctrl_t             ctrl,
    output logic              wr_ctrl,
    output logic              arm_fire,
    output logic [7:0]        rdata,
    output logic              cfg_a_sel,
    output logic              cfg_b_sel
);
    ctrl_t ctrl_q;
    logic  cfg_mode;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign cfg_mode = (ctrl_q.mode == MODE_CFG);

    // Register update: a hardware set of the service flag wins over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode    <= bus_wdata[7:5];
                ctrl_q.err_dis <= bus_wdata[4];
                ctrl_q.dma_en  <= bus_wdata[3];
                ctrl_q.svc     <= bus_wdata[2];
            end
            if (svc_fire) ctrl_q.svc <= 1'b1;
        end
    end

    // Unmasking the fault interrupt while the fault is already active.
    assign arm_fire = wr_ctrl && ctrl_q.err_dis && !bus_wdata[4] && !fault_lvl_n;

    // Read data with live full and empty flags.
    always_comb begin
        rdata = {ctrl_q.mode, ctrl_q.err_dis, ctrl_q.dma_en, ctrl_q.svc,
                 (fifo_free == '0), (fifo_valid == '0)};
    end

    // Configuration register selects, decoded only in configuration mode.
    assign cfg_a_sel = cfg_mode && (bus_addr == ADDR_W'(CFG_A_OFS));
    assign cfg_b_sel = cfg_mode && (bus_addr == ADDR_W'(CFG_B_OFS));

    assign ctrl = ctrl_q;

    // R7: only a software write of 0 may drop the service flag.
    assert_svc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.svc) |-> $past(wr_ctrl && !bus_wdata[2]));

    // R9: at most one configuration select at a time.
    assert_cfg_sel_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_a_sel, cfg_b_sel, wr_ctrl}));

endmodule

// File: rtl/ppsvc_top.sv
// Module: ppsvc_top
// Parallel-port FIFO service interrupt controller. Combines the control
// register, the service trigger evaluation and the fault edge path into a
// registered one-cycle interrupt pulse and a gated DMA enable.
// Assumes fifo_free and fifo_valid come from the same clock domain.
module ppsvc_top
    import ppsvc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned WR_THRESH  = FIFO_DEPTH / 2,
    parameter int unsigned RD_THRESH  = FIFO_DEPTH / 2,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic [CNT_W-1:0]  fifo_free,
    input  logic [CNT_W-1:0]  fifo_valid,
    input  logic              dma_tc,
    input  logic              dir,
    input  logic              fault_n,
    output logic              irq,
    output logic              dma_en_o,
    output logic              cfg_a_sel,
    output logic              cfg_b_sel
);
    ctrl_t ctrl;
    logic  wr_ctrl, arm_fire, svc_fire;
    logic  fault_lvl_n, fault_fall, fault_fire;
    logic  irq_q;

    ppsvc_fault_sync #(.SYNC_STAGES(2)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_n     (fault_n),
        .fault_lvl_n (fault_lvl_n),
        .fault_fall  (fault_fall)
    );

    ppsvc_svc_eval #(
        .CNT_W     (CNT_W),
        .WR_THRESH (WR_THRESH),
        .RD_THRESH (RD_THRESH)
    ) u_eval (
        .svc        (ctrl.svc),
        .dma_en     (ctrl.dma_en),
        .dir        (dir),
        .dma_tc     (dma_tc),
        .fifo_free  (fifo_free),
        .fifo_valid (fifo_valid),
        .svc_fire   (svc_fire)
    );

    ppsvc_ctrl_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .fifo_free   (fifo_free),
        .fifo_valid  (fifo_valid),
        .svc_fire    (svc_fire),
        .fault_lvl_n (fault_lvl_n),
        .ctrl        (ctrl),
        .wr_ctrl     (wr_ctrl),
        .arm_fire    (arm_fire),
        .rdata       (ctrl_rdata),
        .cfg_a_sel   (cfg_a_sel),
        .cfg_b_sel   (cfg_b_sel)
    );

    assign fault_fire = fault_fall & ~ctrl.err_dis;

    // Interrupt pulse register: one clock for each event (merged if they coincide).
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= svc_fire | fault_fire | arm_fire;
    end

    assign irq      = irq_q;
    assign dma_en_o = ctrl.dma_en & ~ctrl.svc;

    // R1: an unmasked synchronized falling edge is followed by a pulse.
    assert_fault_edge_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_fall && !ctrl.err_dis |=> irq);

    // R2: unmasking during an active fault is followed by a pulse.
    assert_unmask_refire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && ctrl.err_dis && !bus_wdata[4] && !fault_lvl_n |=> irq);

    // R7: a hardware set of the service flag always comes with a pulse.
    assert_svc_set_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.svc) && !$past(wr_ctrl && bus_wdata[2]) |-> irq);

endmodule

// File: tb/ppsvc_top_tb.sv
module ppsvc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic [4:0]  fifo_free = 5'd16;
    logic [4:0]  fifo_valid = 5'd0;
    logic        dma_tc = 1'b0;
    logic        dir = 1'b0;
    logic        fault_n = 1'b1;
    logic        irq, dma_en_o, cfg_a_sel, cfg_b_sel;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;

    ppsvc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .fifo_free(fifo_free),
        .fifo_valid(fifo_valid), .dma_tc(dma_tc), .dir(dir), .fault_n(fault_n),
        .irq(irq), .dma_en_o(dma_en_o), .cfg_a_sel(cfg_a_sel), .cfg_b_sel(cfg_b_sel)
    );

    always #4 clk = ~clk;

    // Pulse counter sampled away from the active edge.
    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_at(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        wr_at(11'h402, d);
    endtask

    // Clear the counter, run the stimulus window, compare pulses.
    task automatic expect_irqs(input string req, input int n, input int exp);
        idle(n);
        chk(req, irq_cnt, exp);
        irq_cnt = 0;
    endtask

    task automatic t_reset();
        chk("R10 rdata", ctrl_rdata, 8'h15);
        chk("R10 irq", irq, 0);
        chk("R10 dma_en_o", dma_en_o, 0);
    endtask

    task automatic t_fault();
        irq_cnt = 0;
        wr_ctrl(8'h04);
        expect_irqs("R2 unmask with fault high", 6, 0);
        fault_n = 1'b0;
        expect_irqs("R1 unmasked falling edge", 8, 1);
        fault_n = 1'b1;
        expect_irqs("R1 rising edge", 8, 0);
        wr_ctrl(8'h14);
        fault_n = 1'b0;
        expect_irqs("R1 masked falling edge", 8, 0);
        wr_ctrl(8'h04);
        expect_irqs("R2 unmask with fault low", 6, 1);
        fault_n = 1'b1;
        idle(6);
        wr_ctrl(8'h14);
        wr_ctrl(8'h04);
        expect_irqs("R2 re-unmask fault high", 6, 0);
        wr_ctrl(8'h14);
        irq_cnt = 0;
    endtask

    task automatic t_write_thresh();
        dir = 1'b0; fifo_free = 5'd0; fifo_valid = 5'd0;
        irq_cnt = 0;
        wr_ctrl(8'h10);
        chk("R8 flags full and empty", ctrl_rdata, 8'h13);
        fifo_free = 5'd7;
        expect_irqs("R5 free 7 below threshold", 6, 0);
        fifo_free = 5'd8;
        expect_irqs("R5 free 8 sets service", 4, 1);
        chk("R5 service bit set", ctrl_rdata[2], 1);
        expect_irqs("R7 held condition no re-fire", 20, 0);
        wr_ctrl(8'h14);
        expect_irqs("R7 write one no irq", 6, 0);
        wr_ctrl(8'h10);
        expect_irqs("R7 clear re-arms", 6, 1);
        fifo_free = 5'd0;
    endtask

    task automatic t_read_thresh();
        dir = 1'b1; fifo_free = 5'd16; fifo_valid = 5'd7;
        irq_cnt = 0;
        wr_ctrl(8'h10);
        expect_irqs("R6 valid 7 below threshold", 6, 0);
        chk("R6 service clear", ctrl_rdata[2], 0);
        fifo_valid = 5'd8;
        expect_irqs("R6 valid 8 sets service", 4, 1);
        chk("R6 service bit set", ctrl_rdata[2], 1);
    endtask

    task automatic t_dma();
        dir = 1'b1; fifo_valid = 5'd16; fifo_free = 5'd0;
        irq_cnt = 0;
        wr_ctrl(8'h18);
        chk("R3 dma enabled", dma_en_o, 1);
        expect_irqs("R4 counts ignored in dma", 8, 0);
        @(negedge clk); dma_tc = 1'b1;
        @(negedge clk); dma_tc = 1'b0;
        expect_irqs("R4 terminal count irq", 4, 1);
        chk("R3 dma masked by service", dma_en_o, 0);
        wr_ctrl(8'h1C);
        chk("R3 dma still masked", dma_en_o, 0);
        fifo_valid = 5'd0;
        wr_ctrl(8'h10);
        chk("R3 dma disabled", dma_en_o, 0);
        expect_irqs("R4 no tc no irq", 4, 0);
        wr_ctrl(8'h14);
    endtask

    task automatic t_flags_cfg();
        fifo_free = 5'd5; fifo_valid = 5'd3;
        wr_ctrl(8'h17);
        chk("R8 flags not writable", ctrl_rdata, 8'h14);
        fifo_free = 5'd0;
        idle(1);
        chk("R8 full flag", ctrl_rdata[1:0], 2'b10);
        wr_ctrl(8'hF4);
        chk("R9 mode readback", ctrl_rdata[7:5], 3'd7);
        bus_addr = 11'h400; idle(1);
        chk("R9 cfg_a_sel", {cfg_a_sel, cfg_b_sel}, 2'b10);
        bus_addr = 11'h401; idle(1);
        chk("R9 cfg_b_sel", {cfg_a_sel, cfg_b_sel}, 2'b01);
        wr_at(11'h400, 8'h00);
        chk("R9 other offset not written", ctrl_rdata, 8'hF6);
        wr_ctrl(8'h34);
        bus_addr = 11'h400; idle(1);
        chk("R9 no select outside cfg", {cfg_a_sel, cfg_b_sel}, 2'b00);
        chk("R9 mode 1 readback", ctrl_rdata[7:5], 3'd1);
        bus_addr = '0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fault();
        t_write_thresh();
        t_read_thresh();
        t_dma();
        t_flags_cfg();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule